// File: doc/BRIEF.md
# Snooping Ownership Coherence Line Controller

This block keeps the coherence state of one line in a write-back cache on a snooping bus. It uses an invalidation scheme built on ownership. A cache that holds the line modified is its owner. The owner hands the block directly to any other cache that misses on it, and memory is not updated when the line becomes shared. When no cache owns the line, memory supplies it. The line has four states: Invalid, Valid (clean, possibly shared), Shared-Dirty (modified, shared, and owned here) and Dirty (modified, exclusive, and owned here). A line in either owned state is written back when it is replaced.

The processor side is a valid/ready request channel. It carries one read, write or evict at a time, and a single-cycle `cpu_done` pulse ends each request. The bus side raises one request at a time and completes it in the cycle the external arbiter returns `bus_grant`. Snooped commands arrive on a plain strobe and always take priority over local work. While a snoop is present, any bus request or write-back request is withdrawn. A waiting request is then re-evaluated against the updated line state. `bus_req_cmd` and `wb_valid` may therefore change or drop before they are accepted. This is the one exception to holding valid stable under back-pressure. The tag array, data array, arbiter and memory are outside the block.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset the line is Invalid (`line_state` 0), `cpu_req_ready` is high, and `bus_req_valid`, `wb_valid`, `snp_supply` and `cpu_done` are low.
- R2: A read (op 0) on a line in Valid (1), Shared-Dirty (2) or Dirty (3) completes without a bus request and leaves the state unchanged.
- R3: A read on an Invalid line requests a bus read miss (cmd 0). In the cycle after the grant, `cpu_done` pulses and the line is Valid.
- R4: A write (op 1) to a Dirty line completes with no bus request. A write to a Valid or Shared-Dirty line requests an invalidate (cmd 2), which completes in its single granted cycle and leaves the line Dirty.
- R5: A write to an Invalid line requests a bus write miss (cmd 1). After the grant the line is Dirty.
- R6: A snooped read miss (cmd 0) raises `snp_supply` in the same cycle when the line is Dirty or Shared-Dirty. Dirty becomes Shared-Dirty, the other states are unchanged, and no write-back is requested.
- R7: A snooped write miss (cmd 1) raises `snp_supply` in the same cycle when the line is owned, and leaves the line Invalid.
- R8: A snooped invalidate (cmd 2) leaves the line Invalid and never raises `snp_supply`.
- R9: An evict (op 2) of an owned line holds `wb_valid` until `wb_ready` and then leaves the line Invalid. An evict of a Valid or Invalid line ends Invalid with no write-back.
- R10: While `snp_valid` is high, `bus_req_valid` and `wb_valid` are low. A pending write whose line is invalidated by a snoop switches its request from invalidate to write miss.
- R11: While a request is outstanding, `cpu_req_ready` is low. It completes with exactly one `cpu_done` pulse, one cycle after the cycle in which it finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_op | input | 2 | 0 read, 1 write, 2 evict |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| snp_valid | input | 1 | Snooped bus command present |
| snp_cmd | input | 2 | 0 read miss, 1 write miss, 2 invalidate |
| snp_supply | output | 1 | This cache supplies the block to the requester |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 0 read miss, 1 write miss, 2 invalidate |
| bus_grant | input | 1 | Bus transaction performed this cycle |
| wb_valid | output | 1 | Write-back of owned line requested |
| wb_ready | input | 1 | Write-back accepted this cycle |
| line_state | output | 2 | 0 Invalid, 1 Valid, 2 Shared-Dirty, 3 Dirty |

## Verification
`snp_supply` is combinational, so it is sampled shortly after the snoop is driven, inside the same cycle. The new `line_state` is read at the falling edge after the next rising edge. A processor request is counted in busy cycles from its acceptance edge. A hit finishes in the first busy cycle, and a bus or write-back action finishes in the cycle the bench grants it. `cpu_done` must therefore appear at the falling edge that follows exactly (grant delay + 1) busy cycles. The bench drives that delay at random and checks the pulse position, the requested command, and the final state against a reference function.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LN_INV    = 2'd0,
    LN_VAL    = 2'd1,
    LN_SDIRTY = 2'd2,
    LN_DIRTY  = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BC_RDMISS = 2'd0,
    BC_WRMISS = 2'd1,
    BC_INVAL  = 2'd2,
    BC_NONE   = 2'd3
  } bus_cmd_t;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_EVICT = 2'd2,
    OP_NOP   = 2'd3
  } cpu_op_t;

  function automatic logic is_owned(line_st_t s);
    return (s == LN_DIRTY) || (s == LN_SDIRTY);
  endfunction
endpackage

// File: rtl/coh_snoop.sv
module coh_snoop
  import coh_pkg::*;
(
  input  logic     snp_valid,
  input  bus_cmd_t snp_cmd,
  input  line_st_t cur,
  output line_st_t nxt,
  output logic     supply
);
  always_comb begin
    nxt    = cur;
    supply = 1'b0;
    if (snp_valid) begin
      unique case (snp_cmd)
        BC_RDMISS: begin
          supply = is_owned(cur);
          if (cur == LN_DIRTY) nxt = LN_SDIRTY;
        end
        BC_WRMISS: begin
          supply = is_owned(cur);
          nxt    = LN_INV;
        end
        BC_INVAL: nxt = LN_INV;
        default:  nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/coh_req.sv
module coh_req
  import coh_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cpu_req_valid,
  input  cpu_op_t  cpu_req_op,
  output logic     cpu_req_ready,
  output logic     cpu_done,
  input  logic     snp_valid,
  input  line_st_t cur,
  output logic     bus_req_valid,
  output bus_cmd_t bus_req_cmd,
  input  logic     bus_grant,
  output logic     wb_valid,
  input  logic     wb_ready,
  output logic     fin,
  output line_st_t nxt
);
  logic    busy_q;
  cpu_op_t op_q;

  assign cpu_req_ready = !busy_q;

  always_comb begin
    bus_req_valid = 1'b0;
    bus_req_cmd   = BC_NONE;
    wb_valid      = 1'b0;
    fin           = 1'b0;
    nxt           = cur;
    if (busy_q && !snp_valid) begin
      unique case (op_q)
        OP_READ: begin
          if (cur == LN_INV) begin
            bus_req_valid = 1'b1;
            bus_req_cmd   = BC_RDMISS;
            if (bus_grant) begin
              fin = 1'b1;
              nxt = LN_VAL;
            end
          end else begin
            fin = 1'b1;
          end
        end
        OP_WRITE: begin
          if (cur == LN_DIRTY) begin
            fin = 1'b1;
          end else begin
            bus_req_valid = 1'b1;
            bus_req_cmd   = (cur == LN_INV) ? BC_WRMISS : BC_INVAL;
            if (bus_grant) begin
              fin = 1'b1;
              nxt = LN_DIRTY;
            end
          end
        end
        OP_EVICT: begin
          if (is_owned(cur)) begin
            wb_valid = 1'b1;
            if (wb_ready) begin
              fin = 1'b1;
              nxt = LN_INV;
            end
          end else begin
            fin = 1'b1;
            nxt = LN_INV;
          end
        end
        default: fin = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      op_q     <= OP_READ;
      cpu_done <= 1'b0;
    end else begin
      cpu_done <= fin;
      if (!busy_q && cpu_req_valid) begin
        busy_q <= 1'b1;
        op_q   <= cpu_req_op;
      end else if (fin) begin
        busy_q <= 1'b0;
      end
    end
  end

  AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (!bus_req_valid && !wb_valid)); // R10
  AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done); // R11
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready); // R11
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req_valid,
  input  logic [1:0] cpu_req_op,
  output logic       cpu_req_ready,
  output logic       cpu_done,
  input  logic       snp_valid,
  input  logic [1:0] snp_cmd,
  output logic       snp_supply,
  output logic       bus_req_valid,
  output logic [1:0] bus_req_cmd,
  input  logic       bus_grant,
  output logic       wb_valid,
  input  logic       wb_ready,
  output logic [1:0] line_state
);
  line_st_t st_q, snp_nxt, req_nxt;
  bus_cmd_t req_cmd;
  logic     req_fin;

  coh_snoop u_snoop (
    .snp_valid (snp_valid),
    .snp_cmd   (bus_cmd_t'(snp_cmd)),
    .cur       (st_q),
    .nxt       (snp_nxt),
    .supply    (snp_supply)
  );

  coh_req u_req (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_op    (cpu_op_t'(cpu_req_op)),
    .cpu_req_ready (cpu_req_ready),
    .cpu_done      (cpu_done),
    .snp_valid     (snp_valid),
    .cur           (st_q),
    .bus_req_valid (bus_req_valid),
    .bus_req_cmd   (req_cmd),
    .bus_grant     (bus_grant),
    .wb_valid      (wb_valid),
    .wb_ready      (wb_ready),
    .fin           (req_fin),
    .nxt           (req_nxt)
  );

  assign bus_req_cmd = req_cmd;
  assign line_state  = st_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         st_q <= LN_INV;
    else if (snp_valid) st_q <= snp_nxt;
    else if (req_fin)   st_q <= req_nxt;
  end

  AST_RDMISS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_grant && bus_req_cmd == BC_RDMISS)
      |=> (line_state == LN_VAL && cpu_done)); // R3
  AST_UPGRADE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_grant && bus_req_cmd == BC_INVAL)
      |=> (line_state == LN_DIRTY)); // R4
  AST_WRMISS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_grant && bus_req_cmd == BC_WRMISS)
      |=> (line_state == LN_DIRTY)); // R5
  AST_SNP_SHARE: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == BC_RDMISS && line_state == LN_DIRTY)
      |=> (line_state == LN_SDIRTY)); // R6
  AST_SNP_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == BC_WRMISS) |=> (line_state == LN_INV)); // R7
  AST_INVAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == BC_INVAL) |-> !snp_supply); // R8
  AST_WB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready) |=> (line_state == LN_INV && cpu_done)); // R9
endmodule

// File: tb/coh_line_ctrl_test.sv
module coh_line_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_req_valid = 1'b0;
  logic [1:0] cpu_req_op = 2'd0;
  logic       cpu_req_ready, cpu_done;
  logic       snp_valid = 1'b0;
  logic [1:0] snp_cmd = 2'd0;
  logic       snp_supply, bus_req_valid, wb_valid;
  logic [1:0] bus_req_cmd, line_state;
  logic       bus_grant = 1'b0;
  logic       wb_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [1:0] mst = 2'd0;

  always #10 clk = ~clk;

  coh_line_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_op(cpu_req_op),
    .cpu_req_ready(cpu_req_ready), .cpu_done(cpu_done),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_supply(snp_supply),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_grant(bus_grant),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .line_state(line_state)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // snoop reference: {supply, next state}
  function automatic logic [2:0] snoop_ref(input logic [1:0] st, input logic [1:0] cmd);
    logic own;
    own = (st == 2'd2) || (st == 2'd3);
    case (cmd)
      2'd0: return {own, (st == 2'd3) ? 2'd2 : st};
      2'd1: return {own, 2'd0};
      2'd2: return {1'b0, 2'd0};
      default: return {1'b0, st};
    endcase
  endfunction

  // processor reference: {bus needed, wb needed, cmd, next state}
  function automatic logic [5:0] cpu_ref(input logic [1:0] st, input logic [1:0] op);
    case (op)
      2'd0: return (st == 2'd0) ? {2'b10, 2'd0, 2'd1} : {2'b00, 2'd3, st};
      2'd1: if (st == 2'd3) return {2'b00, 2'd3, 2'd3};
            else return {2'b10, (st == 2'd0) ? 2'd1 : 2'd2, 2'd3};
      2'd2: return (st >= 2'd2) ? {2'b01, 2'd3, 2'd0} : {2'b00, 2'd3, 2'd0};
      default: return {2'b00, 2'd3, st};
    endcase
  endfunction

  task automatic do_snoop(input logic [1:0] cmd);
    logic [2:0] r;
    string tag;
    r = snoop_ref(mst, cmd);
    tag = (cmd == 2'd0) ? "R6" : (cmd == 2'd1) ? "R7" : "R8";
    @(negedge clk);
    snp_valid = 1'b1;
    snp_cmd = cmd;
    #1;
    chk(snp_supply == r[2], {tag, " supply"}, snp_supply, r[2]);
    chk(!wb_valid && !bus_req_valid, "R10 quiet during snoop", wb_valid, 0);
    @(negedge clk);
    snp_valid = 1'b0;
    chk(line_state == r[1:0], {tag, " state"}, line_state, r[1:0]);
    mst = r[1:0];
  endtask

  task automatic do_cpu(input logic [1:0] op, input int delay);
    logic [5:0] r;
    int cyc;
    logic seen;
    string tag;
    r = cpu_ref(mst, op);
    if (op == 2'd2) tag = "R9";
    else if (r[5]) tag = (r[3:2] == 2'd0) ? "R3" : (r[3:2] == 2'd1) ? "R5" : "R4";
    else tag = (op == 2'd0) ? "R2" : "R4";
    @(negedge clk);
    chk(cpu_req_ready, "R11 ready when idle", cpu_req_ready, 1);
    cpu_req_valid = 1'b1;
    cpu_req_op = op;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    cyc = 0;
    seen = 1'b0;
    while (!seen && cyc < 40) begin
      if (cpu_done) begin
        seen = 1'b1;
      end else begin
        chk(!cpu_req_ready, "R11 busy", cpu_req_ready, 0);
        chk(bus_req_valid == r[5], {tag, " bus request"}, bus_req_valid, r[5]);
        if (r[5]) chk(bus_req_cmd == r[3:2], {tag, " bus cmd"}, bus_req_cmd, r[3:2]);
        chk(wb_valid == r[4], {tag, " write-back"}, wb_valid, r[4]);
        bus_grant = (cyc >= delay) && r[5];
        wb_ready = (cyc >= delay) && r[4];
        cyc++;
        @(negedge clk);
        bus_grant = 1'b0;
        wb_ready = 1'b0;
      end
    end
    chk(seen && cyc == ((r[5] || r[4]) ? delay + 1 : 1), "R11 done timing", cyc,
        (r[5] || r[4]) ? delay + 1 : 1);
    chk(line_state == r[1:0], {tag, " state"}, line_state, r[1:0]);
    mst = r[1:0];
    @(negedge clk);
    chk(!cpu_done, "R11 single pulse", cpu_done, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_state == 2'd0, "R1 state", line_state, 0);
    chk(cpu_req_ready && !bus_req_valid && !wb_valid && !snp_supply && !cpu_done,
        "R1 outputs", {cpu_req_ready, bus_req_valid, wb_valid, snp_supply}, 8);

    // directed: miss, share dirty, ownership, eviction
    do_cpu(2'd0, 2);      // R3 read miss
    do_cpu(2'd0, 0);      // R2 read hit Valid
    do_cpu(2'd1, 1);      // R4 upgrade
    do_cpu(2'd1, 0);      // R4 write hit Dirty
    do_snoop(2'd0);       // R6 Dirty -> Shared-Dirty, supply
    do_snoop(2'd0);       // R6 stays Shared-Dirty
    do_cpu(2'd0, 0);      // R2 read hit Shared-Dirty
    do_cpu(2'd2, 3);      // R9 eviction write-back
    do_cpu(2'd1, 0);      // R5 write miss
    do_snoop(2'd1);       // R7 owner supplies, invalid
    do_cpu(2'd2, 0);      // R9 evict invalid

    // R10: invalidate arrives while upgrade waits
    do_cpu(2'd0, 0);
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_op = 2'd1;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    chk(bus_req_valid && bus_req_cmd == 2'd2, "R10 upgrade pending", bus_req_cmd, 2);
    snp_valid = 1'b1;
    snp_cmd = 2'd2;
    #1;
    chk(!bus_req_valid, "R10 withdrawn", bus_req_valid, 0);
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    chk(bus_req_valid && bus_req_cmd == 2'd1, "R10 now write miss", bus_req_cmd, 1);
    bus_grant = 1'b1;
    @(negedge clk);
    bus_grant = 1'b0;
    chk(cpu_done && line_state == 2'd3, "R10 write miss result", line_state, 3);
    mst = 2'd3;
    do_snoop(2'd2);       // R8 invalidate on Dirty: no supply

    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = $urandom % 5;
      if (sel < 3) do_cpu(sel[1:0], $urandom % 4);
      else do_snoop(2'($urandom % 3));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule